// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block is the device-side front end of a synchronous DRAM with two banks. On each rising clock edge it samples the following inputs:

- the chip select, row strobe, column strobe and write enable;
- the clock enable;
- the bank address bit and the address bus.

It turns them into one of six events: activate, read, write, precharge (single bank or all banks), auto-refresh, or nothing. For each bank it keeps an idle/open flag and the row that was opened. A read or write issued with address bit 10 high schedules that bank to close by itself once the burst is over. A precharge or refresh closes banks at once. A command that does not fit the state of its bank sets a sticky error flag. Such a command is otherwise dropped.

The data path sits beside this block and takes its timing from one-cycle registered command strobes. Each strobe comes with a bank number, an address and a precharge qualifier. All of these appear one cycle after the command edge. There is no flowing data at this edge, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal, and the data path must accept every strobe in the cycle it appears.

Top module: `sdram_cmd_front`

## Requirements
- R1: With `cs_n` high at an edge, no strobe is produced and no bank state changes, whatever the other pins carry.
- R2: Activate (`ras_n`=0, `cas_n`=1, `we_n`=1) to an idle bank pulses `act_o` one cycle later. In that cycle `bank_o` equals `ba`, `addr_o` holds the full row, the bank's bit in `bank_open_o` (bit 0 = bank 0) is set, and the row is stored in `open_rows_o` (bank 0 in the low 11 bits).
- R3: Read (`ras_n`=1, `cas_n`=0, `we_n`=1) or write (`ras_n`=1, `cas_n`=0, `we_n`=0) to an open bank pulses `rd_o` or `wr_o`. `addr_o` then carries address bits 8..0 zero-extended, and `ap_o` carries address bit 10.
- R4: Precharge (`ras_n`=0, `cas_n`=1, `we_n`=0) pulses `pre_o`. It closes the bank chosen by `ba`, or both banks when address bit 10 is high. `ap_o` shows bit 10.
- R5: A read or write with address bit 10 high closes its bank at the BURST_LEN-th edge after the command edge; the default BURST_LEN is 4. A later read or write to that bank replaces the pending closure with its own bit-10 choice.
- R6: A precharge to a bank with a pending auto-close cancels that closure. If the bank is opened again, it stays open.
- R7: Auto-refresh (`ras_n`=0, `cas_n`=0, `we_n`=1 with `cke` high) pulses `ref_o`, closes both banks and advances the 12-bit `ref_row_o`, which wraps from 4095 to 0. The same strobes with `cke` low decode as nothing.
- R8: When `cke` is low at an edge, the command at the next edge is ignored.
- R9: Activate to an open bank, or read/write to an idle bank, produces no strobe and changes no bank state. It sets `illegal_o`, which stays high until reset.
- R10: After reset all strobes are low, both banks are idle, `illegal_o` is low and `ref_row_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low selects |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write enable |
| cke | input | 1 | Clock enable |
| ba | input | 1 | Bank select |
| addr | input | 11 | Row / column address; bit 10 is the precharge qualifier |
| act_o | output | 1 | Activate strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| pre_o | output | 1 | Precharge strobe |
| ref_o | output | 1 | Auto-refresh strobe |
| ap_o | output | 1 | Auto-close on read/write, all-banks on precharge |
| bank_o | output | 1 | Bank of the strobed command |
| addr_o | output | 11 | Row on activate, column on read/write, else 0 |
| bank_open_o | output | 2 | Open flag per bank |
| open_rows_o | output | 22 | Stored row per bank |
| illegal_o | output | 1 | Sticky illegal-command flag |
| ref_row_o | output | 12 | Refresh row counter |

## Verification
The auto-close countdown of one bank can end in the same edge that a new command acts on the banks. This is the case to watch. The bench issues a read with bit 10 high to bank 0, then issues an activate to bank 1 exactly BURST_LEN edges later. It expects bank 0 to close and bank 1 to open in the same cycle, with no error. It also issues a precharge inside a countdown, re-opens the bank, and waits past the old deadline. The bank must then stay open, which shows that the cancelled closure does not fire.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF
  } cmd_e;
endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  output cmd_e cmd
);
  // clock enable seen at the previous edge gates decoding now
  logic cke_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end

  always_comb begin
    cmd = CMD_NOP;
    if (cke_q && !cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = cke ? CMD_REF : CMD_NOP;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank #(
  parameter int ROW_W     = 11,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_rdwr,
  input  logic             ap_req,
  input  logic             do_close,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q
);
  localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURST_LEN - 1);

  logic             pend;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      pend    <= 1'b0;
      cnt     <= '0;
      row_q   <= '0;
    end else if (do_close) begin
      is_open <= 1'b0;
      pend    <= 1'b0;
    end else if (do_act) begin
      is_open <= 1'b1;
      row_q   <= row_in;
    end else if (do_rdwr) begin
      pend <= ap_req;
      cnt  <= CNT_LOAD;
    end else if (pend) begin
      if (cnt == '0) begin
        is_open <= 1'b0;
        pend    <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdcmd_refcnt.sv
module sdcmd_refcnt #(
  parameter int REF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [REF_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (!rst_n)    row <= '0;
    else if (step) row <= row + 1'b1;
  end
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdcmd_pkg::*;
#(
  parameter int ROW_W     = 11,
  parameter int COL_W     = 9,
  parameter int BURST_LEN = 4,
  parameter int REF_W     = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               ras_n,
  input  logic               cas_n,
  input  logic               we_n,
  input  logic               cke,
  input  logic               ba,
  input  logic [ROW_W-1:0]   addr,
  output logic               act_o,
  output logic               rd_o,
  output logic               wr_o,
  output logic               pre_o,
  output logic               ref_o,
  output logic               ap_o,
  output logic               bank_o,
  output logic [ROW_W-1:0]   addr_o,
  output logic [1:0]         bank_open_o,
  output logic [2*ROW_W-1:0] open_rows_o,
  output logic               illegal_o,
  output logic [REF_W-1:0]   ref_row_o
);
  localparam int NBANK  = 2;
  localparam int AP_BIT = ROW_W - 1;

  cmd_e cmd;
  logic tgt_open, is_rdwr, act_ok, rw_ok, bad, close_all;
  logic [NBANK-1:0] open_w;
  logic [ROW_W-1:0] row_w [NBANK];

  sdcmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cke(cke), .cmd(cmd)
  );

  always_comb begin
    tgt_open  = open_w[ba];
    is_rdwr   = (cmd == CMD_RD) || (cmd == CMD_WR);
    act_ok    = (cmd == CMD_ACT) && !tgt_open;
    rw_ok     = is_rdwr && tgt_open;
    bad       = ((cmd == CMD_ACT) && tgt_open) || (is_rdwr && !tgt_open);
    close_all = (cmd == CMD_REF) || ((cmd == CMD_PRE) && addr[AP_BIT]);
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel;
    assign sel = (ba == 1'(b));
    sdcmd_bank #(.ROW_W(ROW_W), .BURST_LEN(BURST_LEN)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .do_act  (act_ok && sel),
      .do_rdwr (rw_ok && sel),
      .ap_req  (addr[AP_BIT]),
      .do_close(close_all || ((cmd == CMD_PRE) && sel)),
      .row_in  (addr),
      .is_open (open_w[b]),
      .row_q   (row_w[b])
    );
    assign open_rows_o[b*ROW_W +: ROW_W] = row_w[b];
  end

  assign bank_open_o = open_w;

  sdcmd_refcnt #(.REF_W(REF_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .step(cmd == CMD_REF), .row(ref_row_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_o     <= 1'b0;
      rd_o      <= 1'b0;
      wr_o      <= 1'b0;
      pre_o     <= 1'b0;
      ref_o     <= 1'b0;
      ap_o      <= 1'b0;
      bank_o    <= 1'b0;
      addr_o    <= '0;
      illegal_o <= 1'b0;
    end else begin
      act_o  <= act_ok;
      rd_o   <= rw_ok && (cmd == CMD_RD);
      wr_o   <= rw_ok && (cmd == CMD_WR);
      pre_o  <= (cmd == CMD_PRE);
      ref_o  <= (cmd == CMD_REF);
      ap_o   <= (rw_ok || (cmd == CMD_PRE)) && addr[AP_BIT];
      bank_o <= (act_ok || rw_ok || (cmd == CMD_PRE)) ? ba : 1'b0;
      if (act_ok)     addr_o <= addr;
      else if (rw_ok) addr_o <= ROW_W'(addr[COL_W-1:0]);
      else            addr_o <= '0;
      if (bad) illegal_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sdcmd_checker.sv
module sdcmd_checker #(
  parameter int ROW_W = 11,
  parameter int REF_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             act_o,
  input logic             rd_o,
  input logic             wr_o,
  input logic             pre_o,
  input logic             ref_o,
  input logic             ap_o,
  input logic             bank_o,
  input logic [ROW_W-1:0] addr_o,
  input logic [1:0]       bank_open_o,
  input logic             illegal_o,
  input logic [REF_W-1:0] ref_row_o
);
  // R1
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !(act_o || rd_o || wr_o || pre_o || ref_o));

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_o, rd_o, wr_o, pre_o, ref_o}));

  // R2
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_o |-> bank_open_o[bank_o]);

  // R3
  col_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_o || wr_o) |-> (addr_o[ROW_W-1:ROW_W-2] == 2'b00) && bank_open_o[bank_o]);

  // R4
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_o && ap_o) |-> (bank_open_o == 2'b00));

  // R7
  ref_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_o |-> (bank_open_o == 2'b00) && (ref_row_o == REF_W'($past(ref_row_o) + 1'b1)));

  // R9
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> illegal_o);
endmodule

bind sdram_cmd_front sdcmd_checker #(.ROW_W(ROW_W), .REF_W(REF_W)) u_chk (.*);

// File: tb/tb_sdram_cmd_front.sv
module tb_sdram_cmd_front;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 12;

  // input codes {cs_n, ras_n, cas_n, we_n, cke}
  localparam logic [4:0] C_DSEL = 5'b10001;
  localparam logic [4:0] C_NOP  = 5'b01111;
  localparam logic [4:0] C_ACT  = 5'b00111;
  localparam logic [4:0] C_RD   = 5'b01011;
  localparam logic [4:0] C_WR   = 5'b01001;
  localparam logic [4:0] C_PRE  = 5'b00101;
  localparam logic [4:0] C_REF  = 5'b00011;

  // {code5, ba, addr11 | act,rd,wr,pre,ref, ap, bank, addr_o11, open2}
  localparam logic [36:0] VEC [NVEC] = '{
    {C_DSEL, 1'b1, 11'h7FF, 5'b00000, 1'b0, 1'b0, 11'h000, 2'b00}, // R1
    {C_ACT,  1'b0, 11'h155, 5'b10000, 1'b0, 1'b0, 11'h155, 2'b01}, // R2
    {C_ACT,  1'b1, 11'h2AA, 5'b10000, 1'b0, 1'b1, 11'h2AA, 2'b11}, // R2
    {C_RD,   1'b0, 11'h1FF, 5'b01000, 1'b0, 1'b0, 11'h1FF, 2'b11}, // R3
    {C_WR,   1'b1, 11'h7FF, 5'b00100, 1'b1, 1'b1, 11'h1FF, 2'b11}, // R3
    {C_NOP,  1'b0, 11'h000, 5'b00000, 1'b0, 1'b0, 11'h000, 2'b11}, // R5
    {C_NOP,  1'b0, 11'h000, 5'b00000, 1'b0, 1'b0, 11'h000, 2'b11}, // R5
    {C_NOP,  1'b0, 11'h000, 5'b00000, 1'b0, 1'b0, 11'h000, 2'b11}, // R5
    {C_NOP,  1'b0, 11'h000, 5'b00000, 1'b0, 1'b0, 11'h000, 2'b01}, // R5
    {C_PRE,  1'b0, 11'h000, 5'b00010, 1'b0, 1'b0, 11'h000, 2'b00}, // R4
    {C_ACT,  1'b0, 11'h0A0, 5'b10000, 1'b0, 1'b0, 11'h0A0, 2'b01}, // R2
    {C_REF,  1'b0, 11'h000, 5'b00001, 1'b0, 1'b0, 11'h000, 2'b00}  // R7
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1, ba = 1'b0;
  logic [10:0] addr = '0;
  logic act_o, rd_o, wr_o, pre_o, ref_o, ap_o, bank_o, illegal_o;
  logic [10:0] addr_o;
  logic [1:0]  bank_open_o;
  logic [21:0] open_rows_o;
  logic [11:0] ref_row_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_front dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr),
    .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o), .ref_o(ref_o),
    .ap_o(ap_o), .bank_o(bank_o), .addr_o(addr_o), .bank_open_o(bank_open_o),
    .open_rows_o(open_rows_o), .illegal_o(illegal_o), .ref_row_o(ref_row_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic [4:0] c, input logic b, input logic [10:0] a);
    {cs_n, ras_n, cas_n, we_n, cke} = c;
    ba   = b;
    addr = a;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(C_NOP, 1'b0, '0);
    step(C_NOP, 1'b0, '0);
    rst_n = 1'b1;
  endtask

  function automatic logic [19:0] outs();
    return {act_o, rd_o, wr_o, pre_o, ref_o, ap_o, bank_o, addr_o, bank_open_o};
  endfunction

  initial begin
    @(negedge clk);
    do_reset();
    // R10 reset state
    check("R10 strobes/open", 32'(outs()), 32'h0);
    check("R10 illegal", 32'(illegal_o), 32'h0);
    check("R10 ref_row", 32'(ref_row_o), 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][36:32], VEC[i][31], VEC[i][30:20]);
      check($sformatf("R1-R7 vector %0d", i), 32'(outs()), 32'(VEC[i][19:0]));
    end
    check("R7 ref_row after one refresh", 32'(ref_row_o), 32'd1);
    check("R9 no illegal in table", 32'(illegal_o), 32'h0);

    // R8 clock enable low suspends next command
    do_reset();
    step(5'b01110, 1'b0, '0);
    step(C_ACT, 1'b0, 11'h033);
    check("R8 suspended act", 32'({act_o, bank_open_o}), 32'h0);
    step(C_ACT, 1'b0, 11'h033);
    check("R8 act after resume", 32'({act_o, bank_open_o}), 32'b101);

    // R7 refresh strobes with cke low do nothing
    step(5'b00010, 1'b0, '0);
    check("R7 ref cke low", 32'({ref_o, bank_open_o, ref_row_o}), 32'({1'b0, 2'b01, 12'd0}));
    step(C_NOP, 1'b0, '0);

    // R4 precharge all
    do_reset();
    step(C_ACT, 1'b0, 11'h011);
    step(C_ACT, 1'b1, 11'h022);
    check("R2 rows stored", 32'(open_rows_o), 32'({11'h022, 11'h011}));
    step(C_PRE, 1'b0, 11'h400);
    check("R4 precharge all", 32'({pre_o, ap_o, bank_open_o}), 32'b1100);

    // R6 precharge cancels pending auto-close
    do_reset();
    step(C_ACT, 1'b0, 11'h001);
    step(C_RD,  1'b0, 11'h400);
    step(C_PRE, 1'b0, 11'h000);
    check("R6 closed by precharge", 32'(bank_open_o), 32'b00);
    step(C_ACT, 1'b0, 11'h077);
    for (int k = 0; k < 4; k++) step(C_NOP, 1'b0, '0);
    check("R6 stays open past old deadline", 32'(bank_open_o), 32'b01);

    // R5 auto-close and new activate in the same edge
    do_reset();
    step(C_ACT, 1'b0, 11'h005);
    step(C_RD,  1'b0, 11'h403);
    check("R3 read ap", 32'({rd_o, ap_o, addr_o}), 32'({2'b11, 11'h003}));
    for (int k = 0; k < 3; k++) step(C_NOP, 1'b0, '0);
    check("R5 open before deadline", 32'(bank_open_o), 32'b01);
    step(C_ACT, 1'b1, 11'h00F);
    check("R5 close and open same edge", 32'({act_o, bank_open_o}), 32'b110);
    step(C_ACT, 1'b0, 11'h006);
    check("R5 reopen bank 0", 32'({act_o, bank_open_o, illegal_o}), 32'b1110);

    // R7 refresh counter wrap
    do_reset();
    for (int k = 0; k < 4095; k++) step(C_REF, 1'b0, '0);
    check("R7 ref_row at last", 32'(ref_row_o), 32'd4095);
    step(C_REF, 1'b0, '0);
    check("R7 ref_row wraps", 32'(ref_row_o), 32'd0);

    // R9 read to idle bank
    do_reset();
    step(C_RD, 1'b1, 11'h010);
    check("R9 read idle", 32'({rd_o, bank_open_o, illegal_o}), 32'b0001);
    step(C_NOP, 1'b0, '0);
    check("R9 sticky", 32'(illegal_o), 32'h1);

    // R9 activate to open bank
    do_reset();
    step(C_ACT, 1'b0, 11'h155);
    step(C_ACT, 1'b0, 11'h0FF);
    check("R9 act open bank", 32'({act_o, bank_open_o, illegal_o}), 32'b0011);
    check("R9 row kept", 32'(open_rows_o[10:0]), 32'h155);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule